// File: doc/BRIEF.md
# Dithered Capacitor Array Tuning Controller

This block drives the enable lines of a bank of identical unit capacitors that trim a crystal oscillator. A fine-tuning codeword selects how much capacitance is switched in. The codeword's integer part turns on a contiguous run of elements, starting at element 0. Its fractional part, in sixteenths of one element, is realized over time. A first-order sigma-delta accumulator, stepped once per reference clock, switches one extra element on for the right share of cycles.

The controller runs on the reference clock. Software, or a calibration engine, presents a codeword together with a one-cycle load strobe. The enable input gates the whole array. The accumulator keeps its residue when a new codeword arrives, so the average capacitance moves smoothly between settings without a phase jump in the dither pattern.

Top module: `cap_trim_dither`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every element enable is low. Reset clears the accumulator to zero. With fraction 8 and the enable held high from release, the dithered element is therefore off on the first enabled edge and on at the second.
- R2: The codeword is 14 bits wide. Bits 13..4 are the integer element count and bits 3..0 are the fraction in sixteenths.
- R3: After an enabled edge, elements 0 up to integer-1 are on, and no element above the dithered one is on. The enabled set is always a contiguous run that starts at element 0.
- R4: The dithered element is the one whose index equals the integer count. At each enabled edge the 4-bit accumulator adds the fraction. The dithered element is on for the following cycle exactly when that addition carries out of 4 bits.
- R5: With the codeword held and the enable high, the dithered element is on in exactly fraction cycles out of any 16 consecutive cycles. For example, integer 2 with fraction 7 gives elements 0 and 1 always on and element 2 on 7 times in 16.
- R6: With integer count 1023, element 1023 is never on. The accumulator still advances.
- R7: A codeword presented with the load strobe high governs the output from the edge that samples the strobe. A codeword presented without the strobe has no effect.
- R8: Loading a new codeword does not reset the accumulator. The residue carries into the new fraction's sum.
- R9: An edge sampled with the enable low turns every element off and leaves the accumulator unchanged.
- R10: Fraction 0 never turns the dithered element on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; one modulator step per rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Array and modulator enable |
| load | input | 1 | Codeword capture strobe |
| code_in | input | 14 | Fine-tuning codeword: integer in 13..4, fraction in 3..0 |
| elem_on | output | 1024 | Unit-element enable vector, bit k drives element k |

## Verification
The assertions expect the load strobe and the codeword to be valid at every sampled edge, with no unknown values, and they expect the enable to be a plain level. The properties are written so that any sequence of load, enable and codeword values is legal. The bench draws codewords from $urandom with a fixed seed. It keeps every input driven on the falling edge, so each rising edge samples settled values. It biases the draws toward integer 1023, fraction 0 and fraction 15, so the saturation and no-dither paths appear among the random mix as well as in the directed cases.

// File: rtl/ctd_pkg.sv
package ctd_pkg;

    // Default split of the fine-tuning codeword.
    localparam int unsigned DEF_INT_W  = 10;
    localparam int unsigned DEF_FRAC_W = 4;

    // Stepping mode of the modulator for one cycle.
    typedef enum logic {
        SD_HOLD = 1'b0,
        SD_STEP = 1'b1
    } sd_mode_e;

endpackage

// File: rtl/ctd_sd_mod.sv
module ctd_sd_mod
    import ctd_pkg::*;
#(
    parameter int unsigned FRAC_W = DEF_FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sd_mode_e          mode,
    input  logic [FRAC_W-1:0] frac,
    output logic              carry
);

    localparam int unsigned SUM_W = FRAC_W + 1;

    typedef struct packed {
        logic [FRAC_W-1:0] acc;
    } sd_state_t;

    sd_state_t         st_d;
    sd_state_t         st_q;
    logic [SUM_W-1:0]  sum;

    // Next-state: accumulate the fraction; the carry out is the dither pulse.
    always_comb begin
        st_d  = st_q;
        sum   = {1'b0, st_q.acc} + {1'b0, frac};
        carry = (mode == SD_STEP) ? sum[FRAC_W] : 1'b0;
        if (mode == SD_STEP) begin
            st_d.acc = sum[FRAC_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ctd_array_dec.sv
module ctd_array_dec #(
    parameter int unsigned INT_W = 10
) (
    input  logic [INT_W-1:0]         int_val,
    input  logic                     dith,
    input  logic                     en,
    output logic [(1 << INT_W)-1:0]  vec
);

    localparam int unsigned N_ELEM = 1 << INT_W;

    // One comparator pair per element: static thermometer bit and dither slot.
    for (genvar k = 0; k < N_ELEM; k++) begin : g_elem
        logic therm_bit;
        logic dith_bit;
        assign therm_bit = (int_val > INT_W'(k));
        assign dith_bit  = dith && (int_val == INT_W'(k));
        assign vec[k]    = en && (therm_bit || dith_bit);
    end

endmodule

// File: rtl/cap_trim_dither.sv
module cap_trim_dither
    import ctd_pkg::*;
#(
    parameter int unsigned INT_W  = DEF_INT_W,
    parameter int unsigned FRAC_W = DEF_FRAC_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          en,
    input  logic                          load,
    input  logic [INT_W+FRAC_W-1:0]       code_in,
    output logic [(1 << INT_W)-1:0]       elem_on
);

    localparam int unsigned CODE_W = INT_W + FRAC_W;
    localparam int unsigned N_ELEM = 1 << INT_W;
    localparam logic [INT_W-1:0] INT_MAX = '1;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [N_ELEM-1:0] vec;
    } top_state_t;

    top_state_t        st_d;
    top_state_t        st_q;
    logic [INT_W-1:0]  int_d;
    logic [FRAC_W-1:0] frac_d;
    logic              sd_carry;
    logic              dith_d;
    sd_mode_e          sd_mode;
    logic [N_ELEM-1:0] vec_d;
    logic [CODE_W-1:0] code_q;

    // Next-state: pick the codeword in force for this edge and decide the dither.
    always_comb begin
        st_d      = st_q;
        st_d.code = load ? code_in : st_q.code;
        int_d     = st_d.code[CODE_W-1:FRAC_W];
        frac_d    = st_d.code[FRAC_W-1:0];
        sd_mode   = en ? SD_STEP : SD_HOLD;
        dith_d    = sd_carry && (int_d != INT_MAX);
        st_d.vec  = vec_d;
    end

    ctd_sd_mod #(
        .FRAC_W (FRAC_W)
    ) u_sd (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (sd_mode),
        .frac  (frac_d),
        .carry (sd_carry)
    );

    ctd_array_dec #(
        .INT_W (INT_W)
    ) u_dec (
        .int_val (int_d),
        .dith    (dith_d),
        .en      (en),
        .vec     (vec_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign elem_on = st_q.vec;
    assign code_q  = st_q.code;

endmodule

// File: rtl/cap_trim_dither_chk.sv
module cap_trim_dither_chk #(
    parameter int unsigned INT_W  = 10,
    parameter int unsigned FRAC_W = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          en,
    input logic                          load,
    input logic [INT_W+FRAC_W-1:0]       code_in,
    input logic [(1 << INT_W)-1:0]       elem_on,
    input logic [INT_W+FRAC_W-1:0]       code_q
);

    localparam int unsigned CODE_W = INT_W + FRAC_W;
    localparam int unsigned N_ELEM = 1 << INT_W;

    // R1: first sampled edge after release still shows an empty array
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (elem_on == '0));

    // R3: enabled set is a run starting at element 0
    assert_therm_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((elem_on + 1'b1) & elem_on) == '0);

    // R4: population is the integer count or one more
    assert_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (($countones(elem_on) == int'(code_q[CODE_W-1:FRAC_W])) ||
                ($countones(elem_on) == int'(code_q[CODE_W-1:FRAC_W]) + 1)));

    // R6: top element stays off when the integer part is full scale
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q[CODE_W-1:FRAC_W] == '1) |-> !elem_on[N_ELEM-1]);

    // R7: a loaded integer count shows up at the next edge
    assert_load_effect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load && en) |=> ($countones(elem_on) >= int'($past(code_in[CODE_W-1:FRAC_W]))));

    // R9: disabled edge empties the array
    assert_disable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (elem_on == '0));

    // R10: zero fraction gives exactly the integer count
    assert_zero_frac_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (load && en && (code_in[FRAC_W-1:0] == '0)) |=>
        ($countones(elem_on) == int'($past(code_in[CODE_W-1:FRAC_W]))));

endmodule

bind cap_trim_dither cap_trim_dither_chk #(
    .INT_W  (INT_W),
    .FRAC_W (FRAC_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .load    (load),
    .code_in (code_in),
    .elem_on (elem_on),
    .code_q  (code_q)
);

// File: tb/cap_trim_dither_tb.sv
module cap_trim_dither_tb;

    localparam int unsigned IW = 10;
    localparam int unsigned FW = 4;
    localparam int unsigned CW = IW + FW;
    localparam int unsigned NE = 1 << IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          load = 1'b0;
    logic [CW-1:0] code_in = '0;
    logic [NE-1:0] elem_on;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // Bench reference state
    logic [CW-1:0] m_code = '0;
    logic [FW-1:0] m_acc  = '0;
    logic [NE-1:0] m_exp  = '0;

    always #10 clk = ~clk;

    cap_trim_dither u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .load    (load),
        .code_in (code_in),
        .elem_on (elem_on)
    );

    function automatic logic [NE-1:0] expect_vec(input logic [IW-1:0] n, input logic extra, input logic on);
        logic [NE-1:0] v;
        v = '0;
        if (on) begin
            for (int k = 0; k < NE; k++) begin
                if (k < int'(n)) v[k] = 1'b1;
            end
            if (extra && n != '1) v[n] = 1'b1;
        end
        return v;
    endfunction

    task automatic check(input string tag, input logic ok, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_vec(input string tag);
        int first;
        first = -1;
        for (int k = NE - 1; k >= 0; k--) begin
            if (elem_on[k] !== m_exp[k]) first = k;
        end
        check(tag, first < 0, $countones(elem_on), $countones(m_exp));
        if (first >= 0) $display("  first mismatch at element %0d", first);
    endtask

    // One reference cycle: drive at negedge, model the edge, compare after it.
    task automatic cycle(input logic e, input logic l, input logic [CW-1:0] c, input string tag);
        logic [FW:0] s;
        logic        carry;
        en = e; load = l; code_in = c;
        if (l) m_code = c;
        carry = 1'b0;
        if (e) begin
            s = {1'b0, m_acc} + {1'b0, m_code[FW-1:0]};
            carry = s[FW];
            m_acc = s[FW-1:0];
        end
        m_exp = expect_vec(m_code[CW-1:FW], carry, e);
        @(posedge clk);
        @(negedge clk);
        check_vec(tag);
    endtask

    function automatic logic [CW-1:0] rand_code();
        logic [IW-1:0] n;
        logic [FW-1:0] f;
        int sel;
        sel = int'($urandom_range(0, 9));
        n = IW'($urandom);
        f = FW'($urandom);
        if (sel == 0) n = '1;
        if (sel == 1) f = '0;
        if (sel == 2) f = '1;
        return {n, f};
    endfunction

    initial begin
        #(20 * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int hits;
        void'($urandom(32'd1234));
        code_in = {10'd0, 4'd8};
        repeat (3) @(negedge clk);
        // R1: all off during reset
        check("R1 reset", elem_on == '0, $countones(elem_on), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", elem_on == '0, $countones(elem_on), 0);

        // R1: cleared accumulator with fraction 8 -> off, then on
        cycle(1'b1, 1'b1, {10'd0, 4'd8}, "R1 acc clear");
        check("R1 first step", elem_on[0] == 1'b0, int'(elem_on[0]), 0);
        cycle(1'b1, 1'b0, '0, "R1 acc clear");
        check("R1 second step", elem_on[0] == 1'b1, int'(elem_on[0]), 1);

        // R5: integer 2 fraction 7 -> 7 of 16
        cycle(1'b1, 1'b1, {10'd2, 4'd7}, "R5 load");
        hits = int'(elem_on[2]);
        for (int i = 0; i < 15; i++) begin
            cycle(1'b1, 1'b0, {10'd900, 4'd3}, "R5 R7 ignored code");
            hits += int'(elem_on[2]);
        end
        check("R5 duty 7/16", hits == 7, hits, 7);
        check("R3 run", elem_on[1:0] == 2'b11 && elem_on[NE-1:3] == '0, $countones(elem_on[1:0]), 2);

        // R10: fraction 0 never dithers
        cycle(1'b1, 1'b1, {10'd40, 4'd0}, "R10 load");
        hits = 0;
        for (int i = 0; i < 16; i++) begin
            cycle(1'b1, 1'b0, '0, "R10");
            hits += int'(elem_on[40]);
        end
        check("R10 no dither", hits == 0, hits, 0);

        // R6: full-scale integer with fraction 15
        cycle(1'b1, 1'b1, {10'd1023, 4'd15}, "R6 load");
        hits = 0;
        for (int i = 0; i < 16; i++) begin
            cycle(1'b1, 1'b0, '0, "R6");
            hits += int'(elem_on[NE-1]);
        end
        check("R6 top element", hits == 0, hits, 0);
        check("R6 count", $countones(elem_on) == 1023, $countones(elem_on), 1023);

        // R8: residue carries across a load
        cycle(1'b1, 1'b1, {10'd10, 4'd5}, "R8 residue");
        cycle(1'b1, 1'b1, {10'd11, 4'd12}, "R8 residue");
        cycle(1'b1, 1'b0, '0, "R8 residue");

        // R9: disable empties array and holds accumulator
        cycle(1'b0, 1'b0, '0, "R9 disabled");
        check("R9 empty", elem_on == '0, $countones(elem_on), 0);
        cycle(1'b0, 1'b1, {10'd7, 4'd9}, "R9 R7 load while disabled");
        cycle(1'b1, 1'b0, '0, "R9 resume");

        // R2 R3 R4 R7: random mix
        for (int i = 0; i < 400; i++) begin
            logic e;
            logic l;
            e = ($urandom_range(0, 7) != 0);
            l = ($urandom_range(0, 3) == 0);
            cycle(e, l, rand_code(), "R2 R3 R4 R7 random");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule